// File: doc/BRIEF.md
# PCI Interrupt Router and Acknowledge

This block gathers the four level-sensitive interrupt pins (A, B, C, D) of each PCI slot and presents them to the host. A pin is steered to one of two routing lines: its pin index (A=0 to D=3) is added to the slot's device number and only the lowest bit is kept. A static mode input picks one of two arrangements: in legacy mode the routing lines come out as separate host interrupt outputs, and otherwise every pin is merged into a single shared output meant for host IRQ 15.

The block also holds a one-byte interrupt-acknowledge port on the CPU bus. A single-byte read of that address asks an external interrupt controller for the vector of its highest pending request, holds the CPU transaction until the controller strobes a valid vector, and then returns that byte. Writes there are accepted and ignored, and wider reads complete with an error.

Top module: `pci_irq_router`

## Requirements
- R1: Pin p (A=0 .. D=3) of slot s enters on `pin_irq[4*s+p]`, and slot s has device number s; in legacy mode it drives `legacy_irq[(p+s) & 1]`, so bits 2 and 3 of `legacy_irq` stay 0.
- R2: Routing is level-sensitive and wired-OR: a line is 1 while any pin mapped to it is 1 and returns to 0 once all of them are 0, one clock after the pins are sampled.
- R3: With `legacy_mode` = 0, `shared_irq` is the OR of all pins (one clock later) and `legacy_irq` is all zero.
- R4: With `legacy_mode` = 1, `shared_irq` stays 0.
- R5: A request with `cpu_addr` = ACK_ADDR (0xBFFFFFF0), `cpu_we` = 0 and `cpu_size` = 0 (1 byte) raises `vec_req` on the next cycle, and `vec_req` stays 1 until `vec_valid` is seen.
- R6: The cycle after `vec_valid` is sampled during a fetch, `cpu_ack` is 1 for exactly one cycle with `cpu_rdata` equal to the `vec_data` sampled with the strobe, `cpu_err` = 0, and `vec_req` is 0.
- R7: A write (`cpu_we` = 1) to ACK_ADDR is acknowledged the next cycle with `cpu_err` = 0 and never raises `vec_req`.
- R8: A read of ACK_ADDR with `cpu_size` other than 0 (1 = 2 bytes, 2 = 4 bytes, 3 = reserved) is acknowledged the next cycle with `cpu_err` = 1 and never raises `vec_req`.
- R9: A request to any other address gets no acknowledge and raises no `vec_req`.
- R10: A request presented while a fetch is outstanding is ignored: it causes no further acknowledge and no new fetch.
- R11: During reset `legacy_irq`, `shared_irq`, `vec_req`, `cpu_ack` and `cpu_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | 1 = separate routing outputs, 0 = single shared output |
| pin_irq | input | 4*NUM_SLOTS | Slot interrupt pins, slot s pin p at bit 4*s+p |
| legacy_irq | output | 4 | Routed lines in legacy mode |
| shared_irq | output | 1 | Merged interrupt in shared mode |
| cpu_req | input | 1 | One-cycle CPU request strobe |
| cpu_addr | input | ADDR_W | Request address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2, 2 = 4 |
| cpu_ack | output | 1 | One-cycle completion strobe |
| cpu_err | output | 1 | Error flag, valid with `cpu_ack` |
| cpu_rdata | output | VEC_W | Vector byte returned by a fetch |
| vec_req | output | 1 | Vector fetch request to the controller |
| vec_valid | input | 1 | Controller strobe: `vec_data` holds the vector |
| vec_data | input | VEC_W | Vector byte from the controller |

## Verification
Routing and the acknowledge handshake share no state, so the risk is that a fetch completing disturbs the interrupt lines or that a pin edge in the completion cycle disturbs the returned byte. The bench changes the pin pattern in the very cycle the controller strobes its vector, and also presents a fresh request in that cycle, then checks both the routed outputs against its own routing function and the single acknowledge against the strobed byte. A request held off until the fetch ends must yield no second acknowledge and no new `vec_req`.

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W = 32,
  parameter int VEC_W = 8,
  parameter logic [ADDR_W-1:0] ACK_ADDR = 32'hBFFF_FFF0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   legacy_mode,
  input  logic [4*NUM_SLOTS-1:0] pin_irq,
  output logic [3:0]             legacy_irq,
  output logic                   shared_irq,
  input  logic                   cpu_req,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic                   cpu_we,
  input  logic [1:0]             cpu_size,
  output logic                   cpu_ack,
  output logic                   cpu_err,
  output logic [VEC_W-1:0]       cpu_rdata,
  output logic                   vec_req,
  input  logic                   vec_valid,
  input  logic [VEC_W-1:0]       vec_data
);
  localparam int PINS = 4;
  localparam int NSRC = PINS * NUM_SLOTS;

  typedef enum logic {S_IDLE, S_FETCH} ack_state_t;
  ack_state_t state;

  logic [1:0] line_c;
  logic       any_c;
  logic       hit;

  always_comb begin
    line_c = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int p = 0; p < PINS; p++)
        if (pin_irq[s*PINS+p]) line_c[(p + s) & 1] = 1'b1;
  end

  assign any_c = |pin_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      legacy_irq <= '0;
      shared_irq <= 1'b0;
    end else begin
      legacy_irq <= legacy_mode ? {2'b00, line_c} : 4'b0000;
      shared_irq <= legacy_mode ? 1'b0 : any_c;
    end
  end

  assign hit = cpu_req && (cpu_addr == ACK_ADDR) && (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      vec_req   <= 1'b0;
      cpu_ack   <= 1'b0;
      cpu_err   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ack <= 1'b0;
      cpu_err <= 1'b0;
      case (state)
        S_IDLE: if (hit) begin
          if (cpu_we) begin
            cpu_ack <= 1'b1;
          end else if (cpu_size != 2'd0) begin
            cpu_ack <= 1'b1;
            cpu_err <= 1'b1;
          end else begin
            state   <= S_FETCH;
            vec_req <= 1'b1;
          end
        end
        S_FETCH: if (vec_valid) begin
          state     <= S_IDLE;
          vec_req   <= 1'b0;
          cpu_ack   <= 1'b1;
          cpu_rdata <= vec_data;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_shared_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(legacy_mode)) |-> (shared_irq == $past(any_c)) && (legacy_irq == 4'b0000));
  p_shared_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(legacy_mode) |-> !shared_irq);
  p_upper_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_irq[3:2] == 2'b00);
  p_req_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !vec_valid) |=> vec_req);
  p_ack_on_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && vec_valid) |=> (cpu_ack && !cpu_err && !vec_req && cpu_rdata == $past(vec_data)));
  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
  p_err_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_ack);
  p_no_ack_fetching_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !vec_valid) |=> !cpu_ack);
endmodule

// File: tb/pci_irq_router_bench.sv
`timescale 1ns/1ps
module pci_irq_router_bench;
  localparam int NS = 4;
  localparam logic [31:0] AA = 32'hBFFF_FFF0;

  logic clk = 0, rst_n = 0, legacy_mode = 1;
  logic [4*NS-1:0] pin_irq = '0;
  logic [3:0] legacy_irq;
  logic shared_irq, cpu_req = 0, cpu_we = 0, cpu_ack, cpu_err, vec_req, vec_valid = 0;
  logic [31:0] cpu_addr = '0;
  logic [1:0] cpu_size = '0;
  logic [7:0] cpu_rdata, vec_data = '0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pci_irq_router #(.NUM_SLOTS(NS)) u_pci_irq_router (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .pin_irq(pin_irq),
    .legacy_irq(legacy_irq), .shared_irq(shared_irq), .cpu_req(cpu_req),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_ack(cpu_ack),
    .cpu_err(cpu_err), .cpu_rdata(cpu_rdata), .vec_req(vec_req),
    .vec_valid(vec_valid), .vec_data(vec_data));

  function automatic logic [3:0] exp_legacy(logic m, logic [4*NS-1:0] p);
    logic [3:0] r = '0;
    if (m) for (int s = 0; s < NS; s++) for (int k = 0; k < 4; k++)
      if (p[4*s+k]) r[(k + s) % 2] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_shared(logic m, logic [4*NS-1:0] p);
    return !m && (p != '0);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_routing(string tag, logic m, logic [4*NS-1:0] p);
    chk({tag, " legacy_irq"}, {28'd0, legacy_irq}, {28'd0, exp_legacy(m, p)});
    chk({tag, " shared_irq"}, {31'd0, shared_irq}, {31'd0, exp_shared(m, p)});
  endtask

  task automatic issue(logic [31:0] a, logic we, logic [1:0] sz);
    cpu_req = 1; cpu_addr = a; cpu_we = we; cpu_size = sz;
    step();
    cpu_req = 0;
  endtask

  task automatic fetch(int wait_cycles, logic [7:0] v, string tag);
    issue(AA, 0, 2'd0);
    chk({tag, " R5 vec_req raised"}, {31'd0, vec_req}, 32'd1);
    chk({tag, " R5 no early ack"}, {31'd0, cpu_ack}, 32'd0);
    for (int i = 0; i < wait_cycles; i++) begin
      step();
      chk({tag, " R5 vec_req held"}, {31'd0, vec_req}, 32'd1);
      chk({tag, " R10 no ack while waiting"}, {31'd0, cpu_ack}, 32'd0);
    end
    vec_valid = 1; vec_data = v;
    step();
    vec_valid = 0; vec_data = $urandom;
    chk({tag, " R6 ack"}, {31'd0, cpu_ack}, 32'd1);
    chk({tag, " R6 rdata"}, {24'd0, cpu_rdata}, {24'd0, v});
    chk({tag, " R6 err"}, {31'd0, cpu_err}, 32'd0);
    chk({tag, " R6 vec_req dropped"}, {31'd0, vec_req}, 32'd0);
    step();
    chk({tag, " R6 single ack"}, {31'd0, cpu_ack}, 32'd0);
  endtask

  initial begin
    #(5ns * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    pin_irq = '1;
    @(negedge clk); step();
    chk("R11 reset legacy_irq", {28'd0, legacy_irq}, 32'd0);
    chk("R11 reset shared_irq", {31'd0, shared_irq}, 32'd0);
    chk("R11 reset vec_req", {31'd0, vec_req}, 32'd0);
    chk("R11 reset cpu_ack", {30'd0, cpu_ack, cpu_err}, 32'd0);
    pin_irq = '0;
    rst_n = 1;
    step();

    // R1 directed: each single pin alone in legacy mode
    legacy_mode = 1;
    for (int b = 0; b < 4*NS; b++) begin
      pin_irq = '0; pin_irq[b] = 1'b1;
      step();
      chk($sformatf("R1 single pin %0d", b), {28'd0, legacy_irq},
          {28'd0, 4'b0001 << (((b % 4) + (b / 4)) % 2)});
    end
    // R2 wired-OR: two pins on line 0, drop one then the other
    pin_irq = '0; pin_irq[0] = 1; pin_irq[5] = 1;
    step(); chk("R2 both sharing line0", {28'd0, legacy_irq}, 32'd1);
    pin_irq[0] = 0;
    step(); chk("R2 one source left", {28'd0, legacy_irq}, 32'd1);
    pin_irq[5] = 0;
    step(); chk("R2 all released", {28'd0, legacy_irq}, 32'd0);

    // R1 R2 R3 R4 random patterns in both modes
    for (int i = 0; i < 400; i++) begin
      if (i % 100 == 0) legacy_mode = (i / 100) % 2 == 0;
      pin_irq = ($urandom % 3 == 0) ? '0 : (4*NS)'($urandom);
      step();
      chk_routing(legacy_mode ? "R1 R2 R4 random" : "R3 random", legacy_mode, pin_irq);
    end
    legacy_mode = 0; pin_irq = 16'h8000;
    step(); chk_routing("R3 top pin only", 0, pin_irq);

    // R5 R6 fetches with different waits
    legacy_mode = 1;
    fetch(0, 8'hA5, "zero wait");
    fetch(3, 8'h0F, "three wait");
    for (int i = 0; i < 20; i++) fetch($urandom % 6, 8'($urandom), "random");

    // R7 write ignored
    issue(AA, 1, 2'd0);
    chk("R7 write ack", {31'd0, cpu_ack}, 32'd1);
    chk("R7 write err", {31'd0, cpu_err}, 32'd0);
    chk("R7 write no vec_req", {31'd0, vec_req}, 32'd0);
    step();
    chk("R7 still no vec_req", {31'd0, vec_req}, 32'd0);

    // R8 wide reads
    for (int sz = 1; sz < 4; sz++) begin
      issue(AA, 0, 2'(sz));
      chk($sformatf("R8 size %0d ack", sz), {31'd0, cpu_ack}, 32'd1);
      chk($sformatf("R8 size %0d err", sz), {31'd0, cpu_err}, 32'd1);
      chk($sformatf("R8 size %0d vec_req", sz), {31'd0, vec_req}, 32'd0);
      step();
    end

    // R9 other addresses
    for (int i = 0; i < 6; i++) begin
      issue((i == 0) ? AA + 1 : (i == 1) ? AA - 16 : $urandom | 32'h1, i % 2 == 1, 2'd0);
      chk("R9 no ack", {31'd0, cpu_ack}, 32'd0);
      chk("R9 no vec_req", {31'd0, vec_req}, 32'd0);
    end

    // R10 + concurrency: pins change and a new request arrives as the vector returns
    issue(AA, 0, 2'd0);
    issue(AA, 0, 2'd0);
    chk("R10 second request no ack", {31'd0, cpu_ack}, 32'd0);
    chk("R10 fetch still pending", {31'd0, vec_req}, 32'd1);
    vec_valid = 1; vec_data = 8'h3C; pin_irq = 16'h0012;
    cpu_req = 1; cpu_addr = AA; cpu_we = 1; cpu_size = 0;
    step();
    cpu_req = 0; vec_valid = 0;
    chk("R6 concurrent ack", {31'd0, cpu_ack}, 32'd1);
    chk("R6 concurrent rdata", {24'd0, cpu_rdata}, 32'h3C);
    chk_routing("R2 concurrent routing", 1, pin_irq);
    step();
    chk("R10 no ack for request during fetch", {31'd0, cpu_ack}, 32'd0);
    chk("R10 no new fetch", {31'd0, vec_req}, 32'd0);
    step();
    chk("R10 still idle", {31'd0, vec_req}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule